// File: doc/BRIEF.md
# Edge-Triggered Wake and Interrupt Aggregator

This block watches sixteen asynchronous input channels and turns selected transitions on them into steady interrupt levels. Each channel has an enable, an edge-sense bit that picks rising or falling transitions, and a sticky pending flag. Software assigns every channel to one of four interrupt lines. An interrupt line stays high while any enabled, pending channel assigned to it is set. This suits an interrupt controller that samples levels and would miss a single-cycle pulse.

The block also drives a wake request to a low-power controller. The request is the OR of all enabled pending flags, so a qualifying transition can bring the system out of halt, idle or power-save mode whichever line the channel is routed to. Software reaches the block through a small register port with a single-cycle write strobe and a combinational read.

Top module: `ewk_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads 0: enables off, pending clear, edge sense rising (0), all channels routed to line 0. `irq_out` and `wake_req` are low.
- R2: Register map at `reg_addr`: 0 enable (bit n = channel n), 1 edge sense (bit n: 0 rising, 1 falling), 2 pending, 3 line select for channels 0-7 (bits [2n+1:2n] for channel n), 4 line select for channels 8-15 (bits [2(n-8)+1:2(n-8)]). Addresses 5-7 read 0 and ignore writes. Registers 0, 1, 3 and 4 read back what was written.
- R3: Each input passes through two synchronizing flops. A pin change driven before clock edge k sets pending at edge k+2, so it is visible after the third rising edge and not after the second.
- R4: With edge sense 0, a low-to-high transition on an enabled channel sets its pending bit and a high-to-low transition does not.
- R5: With edge sense 1, a high-to-low transition sets pending and a low-to-high transition does not.
- R6: Transitions on a disabled channel are not latched. Pending stays clear even after the channel is enabled later.
- R7: Writing 1 to a bit of register 2 clears that pending bit. Bits written 0 are unchanged. Pending bits are never cleared by any other write.
- R8: If a clear of a pending bit and a new qualifying transition on that channel land in the same cycle, the bit ends up set.
- R9: `irq_out[g]` is high exactly when some channel whose line select equals g is both enabled and pending.
- R10: Disabling a pending channel removes it from `irq_out` and `wake_req` but keeps its pending bit. Re-enabling restores the outputs.
- R11: `wake_req` is high exactly when any channel is both enabled and pending, whichever line it is routed to.
- R12: Changing a channel's edge sense while its input is steady does not set its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_in | input | 16 | Asynchronous channel inputs |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_out | output | 4 | Level interrupt lines |
| wake_req | output | 1 | Wake request to the low-power controller |

## Verification
The bench targets four corner cases:
- **Synchronizer latency.** A design with one flop too few or too many shows pending one cycle early or late.
- **Clear colliding with a new transition.** A design that lets the clear win loses the interrupt.
- **Edge-sense flip on a quiet low input.** A design without the history reload latches a spurious transition.
- **Disabled channels.** A design that latches while disabled raises an interrupt as soon as the channel is enabled.

A random phase mixes sparse pin toggles with random register writes. It compares every output against a behavioural model on every clock.

// File: rtl/ewk_pkg.sv
// Shared definitions for the edge wake aggregator.
// Assumes a 3-bit register address and a 16-bit data word.
package ewk_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_ENABLE  = 3'd0,
        ADDR_SENSE   = 3'd1,
        ADDR_PENDING = 3'd2,
        ADDR_LSEL_LO = 3'd3,
        ADDR_LSEL_HI = 3'd4
    } ewk_addr_e;
endpackage

// File: rtl/ewk_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module ewk_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Capture and re-register the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/ewk_edge.sv
// Polarity-normalised transition detector.
// The synchronized level is XORed with the edge-sense bit, so both edge
// senses reduce to a rising edge of the normalised value. When software
// changes a channel's sense, that channel's history is reloaded with the
// level normalised by the new sense, and the detection is masked for
// that cycle. This keeps a sense change from looking like a transition.
module ewk_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] sense_chg,
    input  logic [W-1:0] sense_new,
    output logic [W-1:0] hit
);
    logic [W-1:0] norm;
    logic [W-1:0] hist_q;

    assign norm = level ^ sense;
    assign hit  = norm & ~hist_q & ~sense_chg;

    // Remember the previous normalised level, reloading on a sense change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= (norm & ~sense_chg) | ((level ^ sense_new) & sense_chg);
        end
    end

    // R12: the cycle after a sense change, a channel whose level held still reports no transition.
    assert_no_false_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|sense_chg) |=> ((hit & $past(sense_chg) & ~(level ^ $past(level))) == '0));
endmodule

// File: rtl/ewk_route.sv
// Routes active channels onto interrupt lines and builds the wake request.
// Assumes a line-select field of $clog2(NUM_GRP) bits per channel, packed
// with channel 0 in the least significant field.
module ewk_route #(
    parameter int NUM_CH  = 16,
    parameter int NUM_GRP = 4,
    parameter int SEL_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       active,
    input  logic [NUM_CH*SEL_W-1:0] line_sel,
    output logic [NUM_GRP-1:0]      irq,
    output logic                    wake
);
    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_line
            // OR together the active channels assigned to line g.
            always_comb begin
                irq[g] = 1'b0;
                for (int c = 0; c < NUM_CH; c++) begin
                    if (int'(line_sel[c*SEL_W +: SEL_W]) == g) begin
                        irq[g] = irq[g] | active[c];
                    end
                end
            end
        end
    endgenerate

    assign wake = |active;

    // R11: the wake request agrees with the union of the interrupt lines.
    assert_wake_matches_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake == (|irq));
endmodule

// File: rtl/ewk_ctrl.sv
// Edge wake aggregator top level: register file, pending logic and
// instances of the synchronizer, the detector and the router.
// Assumes NUM_CH equals the data width and that the line-select fields
// fill exactly two data words (16 channels, 4 lines).
module ewk_ctrl
    import ewk_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int NUM_GRP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   chan_in,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NUM_CH-1:0]   reg_wdata,
    output logic [NUM_CH-1:0]   reg_rdata,
    output logic [NUM_GRP-1:0]  irq_out,
    output logic                wake_req
);
    localparam int DATA_W = NUM_CH;
    localparam int SEL_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int LSEL_W = NUM_CH * SEL_W;

    logic [NUM_CH-1:0] en_q, sense_q, pend_q;
    logic [LSEL_W-1:0] lsel_q;
    logic [NUM_CH-1:0] lvl, hit, sense_chg, clr_vec;
    logic              wr_en, wr_sense, wr_pend, wr_lo, wr_hi;

    // Decode which register a write targets.
    always_comb begin
        wr_en    = reg_wr && (ewk_addr_e'(reg_addr) == ADDR_ENABLE);
        wr_sense = reg_wr && (ewk_addr_e'(reg_addr) == ADDR_SENSE);
        wr_pend  = reg_wr && (ewk_addr_e'(reg_addr) == ADDR_PENDING);
        wr_lo    = reg_wr && (ewk_addr_e'(reg_addr) == ADDR_LSEL_LO);
        wr_hi    = reg_wr && (ewk_addr_e'(reg_addr) == ADDR_LSEL_HI);
    end

    assign sense_chg = wr_sense ? (reg_wdata ^ sense_q) : '0;
    assign clr_vec   = wr_pend ? reg_wdata : '0;

    ewk_sync #(.W(NUM_CH)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (chan_in),
        .sync_out (lvl)
    );

    ewk_edge #(.W(NUM_CH)) edge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (lvl),
        .sense     (sense_q),
        .sense_chg (sense_chg),
        .sense_new (reg_wdata),
        .hit       (hit)
    );

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            sense_q <= '0;
            lsel_q  <= '0;
        end else begin
            if (wr_en)    en_q    <= reg_wdata;
            if (wr_sense) sense_q <= reg_wdata;
            if (wr_lo)    lsel_q[DATA_W-1:0]        <= reg_wdata;
            if (wr_hi)    lsel_q[2*DATA_W-1:DATA_W] <= reg_wdata;
        end
    end

    // Sticky pending flags: a new transition outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | (hit & en_q);
        end
    end

    // Return the addressed register; unmapped addresses read zero.
    always_comb begin
        case (ewk_addr_e'(reg_addr))
            ADDR_ENABLE:  reg_rdata = en_q;
            ADDR_SENSE:   reg_rdata = sense_q;
            ADDR_PENDING: reg_rdata = pend_q;
            ADDR_LSEL_LO: reg_rdata = lsel_q[DATA_W-1:0];
            ADDR_LSEL_HI: reg_rdata = lsel_q[2*DATA_W-1:DATA_W];
            default:      reg_rdata = '0;
        endcase
    end

    ewk_route #(.NUM_CH(NUM_CH), .NUM_GRP(NUM_GRP), .SEL_W(SEL_W)) route_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (pend_q & en_q),
        .line_sel (lsel_q),
        .irq      (irq_out),
        .wake     (wake_req)
    );

    // R1: one reset cycle leaves the enables, the flags and the outputs cleared.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0 && irq_out == '0 && !wake_req));

    // R6: a flag can only become set on a channel that was enabled.
    assert_disabled_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R7: a set flag that was not written with 1 stays set.
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));

    // R8: a clear that coincides with an enabled transition leaves the flag set.
    assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & hit & en_q)) |=>
        ((pend_q & $past(clr_vec & hit & en_q)) == $past(clr_vec & hit & en_q)));
endmodule

// File: tb/ewk_ctrl_tb_top.sv
`timescale 1ns/1ps
module ewk_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] chan_in = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  irq_out;
    logic        wake_req;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ewk_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_in   (chan_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out),
        .wake_req  (wake_req)
    );

    // Behavioural reference state.
    logic [15:0] m_s1, m_s2, m_prev, m_en, m_sense, m_pend;
    logic [31:0] m_lsel;
    logic [15:0] m_hit, m_clr, m_chg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            m_en = '0; m_sense = '0; m_pend = '0; m_lsel = '0;
        end else begin
            for (int c = 0; c < 16; c++)
                m_hit[c] = m_sense[c] ? (m_prev[c] && !m_s2[c]) : (!m_prev[c] && m_s2[c]);
            m_chg = (reg_wr && reg_addr == 3'd1) ? (reg_wdata ^ m_sense) : 16'h0;
            m_clr = (reg_wr && reg_addr == 3'd2) ? reg_wdata : 16'h0;
            m_hit = m_hit & ~m_chg;
            m_pend = (m_pend & ~m_clr) | (m_hit & m_en);
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_en = reg_wdata;
                    3'd1: m_sense = reg_wdata;
                    3'd3: m_lsel[15:0] = reg_wdata;
                    3'd4: m_lsel[31:16] = reg_wdata;
                    default: ;
                endcase
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = chan_in;
        end
    end

    function automatic logic [3:0] exp_irq();
        logic [3:0] r = '0;
        for (int c = 0; c < 16; c++)
            if (m_en[c] && m_pend[c]) r[m_lsel[2*c +: 2]] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_en;
            3'd1: return m_sense;
            3'd2: return m_pend;
            3'd3: return m_lsel[15:0];
            3'd4: return m_lsel[31:16];
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the reference on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq lines", {12'h0, irq_out}, {12'h0, exp_irq()});
            chk("R11 wake", {15'h0, wake_req}, {15'h0, |(m_en & m_pend)});
            chk("R2 read data", reg_rdata, exp_rd(reg_addr));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
        reg_addr = a;
        #0.2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(4);
        // R1: reset state, before reset is released.
        chk("R1 irq", {12'h0, irq_out}, 16'h0);
        chk("R1 wake", {15'h0, wake_req}, 16'h0);
        rst_n = 1'b1;
        step(1);
        for (int a = 0; a < 5; a++) rd("R1 reg reset", 3'(a), 16'h0);

        wr(3'd0, 16'h00FF);
        wr(3'd3, 16'h00E4);           // ch0->0, ch1->1, ch2->2, ch3->3

        // R3 and R4: latency and rising edge on channel 0.
        chan_in[0] = 1'b1;
        step(2);
        rd("R3 not yet", 3'd2, 16'h0000);
        step(1);
        rd("R3 R4 rising set", 3'd2, 16'h0001);
        chk("R9 line0", {12'h0, irq_out}, 16'h0001);
        wr(3'd2, 16'h0001);
        chan_in[0] = 1'b0;
        step(4);
        rd("R4 falling ignored", 3'd2, 16'h0000);

        // R5: falling sense on channel 1.
        wr(3'd1, 16'h0002);
        chan_in[1] = 1'b1;
        step(4);
        rd("R5 rising ignored", 3'd2, 16'h0000);
        chan_in[1] = 1'b0;
        step(4);
        rd("R5 falling set", 3'd2, 16'h0002);
        chk("R9 line1", {12'h0, irq_out}, 16'h0002);

        // R12: flip sense on a quiet low channel 3.
        wr(3'd2, 16'hFFFF);
        wr(3'd1, 16'h000A);
        step(3);
        rd("R12 no false edge", 3'd2, 16'h0000);

        // R6: transitions on disabled channel 8.
        chan_in[8] = 1'b1; step(4);
        chan_in[8] = 1'b0; step(4);
        wr(3'd0, 16'h01FF);
        rd("R6 not latched", 3'd2, 16'h0000);
        chk("R6 irq quiet", {12'h0, irq_out}, 16'h0);

        // R7: partial write-one-to-clear.
        chan_in[0] = 1'b1; chan_in[2] = 1'b1;
        step(4);
        rd("R7 both set", 3'd2, 16'h0005);
        wr(3'd2, 16'h0004);
        rd("R7 one cleared", 3'd2, 16'h0001);
        wr(3'd2, 16'h0000);
        rd("R7 zeros ignored", 3'd2, 16'h0001);

        // R8: clear lands in the same cycle as a new edge on channel 2.
        chan_in[2] = 1'b0; step(4);
        chan_in[2] = 1'b1;
        step(2);
        wr(3'd2, 16'h0005);
        rd("R8 edge wins", 3'd2, 16'h0004);
        chk("R9 line2", {12'h0, irq_out}, 16'h0004);

        // R10: masking by enable keeps the flag.
        wr(3'd0, 16'h01FB);
        chk("R10 irq masked", {12'h0, irq_out}, 16'h0);
        chk("R10 wake masked", {15'h0, wake_req}, 16'h0);
        rd("R10 flag kept", 3'd2, 16'h0004);
        wr(3'd0, 16'h01FF);
        chk("R10 irq back", {12'h0, irq_out}, 16'h0004);

        // R11: rerouting does not change the wake request.
        wr(3'd3, 16'h0000);
        chk("R11 routed line0", {12'h0, irq_out}, 16'h0001);
        chk("R11 wake held", {15'h0, wake_req}, 16'h0001);

        // R2: map and unmapped addresses.
        wr(3'd5, 16'hFFFF);
        rd("R2 enable kept", 3'd0, 16'h01FF);
        rd("R2 unmapped", 3'd5, 16'h0000);
        rd("R2 sense", 3'd1, 16'h000A);
        wr(3'd4, 16'hA5C3);
        rd("R2 lsel hi", 3'd4, 16'hA5C3);

        // Random traffic checked cycle by cycle against the model.
        for (int i = 0; i < 3000; i++) begin
            chan_in = chan_in ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
            if (($urandom % 4) == 0) begin
                reg_wr = 1'b1;
                reg_addr = 3'($urandom);
                reg_wdata = 16'($urandom);
            end else begin
                reg_wr = 1'b0;
                reg_addr = 3'($urandom);
            end
            step(1);
        end
        reg_wr = 1'b0;
        step(2);
        finish_run();
    end
endmodule